// File: doc/BRIEF.md
# Quadword Block-Copy DMA Channel

This block is a single DMA channel that copies a contiguous run of 128-bit quadwords from one memory region to another. Software programs four registers through a small write port with combinational read-back: a transfer length counted in quadwords, a source address, a target address and a control word. Setting the control word's go bit starts the copy. The engine then alternates between reading one quadword from the source and writing it to the destination. The destination address is the programmed target plus a fixed relocation base, which is a parameter.

The memory side has a read port and a write port. Each port holds its request, address and data until the memory answers with a ready in the same cycle. When the last beat is written, the count register reads zero and the go bit reads zero. The channel-done interrupt is asserted for one cycle. Software can cancel a running copy by writing the control word with the go bit clear. A cancelled copy raises no interrupt, and the count and address registers keep the progress reached so far.

Top module: `dma_qw_copy`

## Requirements
- R1: After reset the control, count, source and target registers all read zero, and no memory request and no interrupt are active.
- R2: Registers sit 16 bytes apart and are selected by offset/16: control at 0x00, count at 0x10, source at 0x20, target at 0x30. While idle, a write to one of them reads back. The count register keeps the low 16 bits of the written data. A write or read at an offset whose low four bits are not zero touches nothing and reads zero.
- R3: A control write with bit 0 set while idle starts a transfer. Bit 0 of the control register reads 1 from the next cycle until the channel returns to idle. While idle, no memory request is active.
- R4: Each quadword is one beat. The read request carries source + 16*k. The following write request carries target + DEST_BASE + 16*k and the data returned by that read. Exactly count beats occur, so count*16 bytes move, and read and write requests never overlap.
- R5: A pending request keeps its address, and its write data, stable until the ready is seen.
- R6: After the last beat the count reads 0 and control bit 0 reads 0. The source and target registers read their start values plus 16*count. ch_done_irq is high for exactly one cycle.
- R7: A start with count zero issues no memory request, and ch_done_irq is asserted in the cycle after the start.
- R8: While a transfer runs, writes to the count, source and target registers are ignored, and so are control writes with bit 0 set.
- R9: A control write with bit 0 clear during a transfer cancels it. No further request and no interrupt follow. The count holds the beats not yet done, and the address registers hold their advanced values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mem_rd_req | output | 1 | Read request |
| mem_rd_addr | output | 32 | Read byte address |
| mem_rd_rdy | input | 1 | Read accepted, data valid this cycle |
| mem_rd_data | input | 128 | Read quadword |
| mem_wr_req | output | 1 | Write request |
| mem_wr_addr | output | 32 | Write byte address (relocated) |
| mem_wr_data | output | 128 | Write quadword |
| mem_wr_rdy | input | 1 | Write accepted |
| ch_done_irq | output | 1 | One-cycle channel-done pulse |

## Verification
The assertions check on every cycle:
- Read and write requests never overlap.
- A waiting request holds its address and data.
- Every beat steps the count down by one and both addresses up by 16.
- Registers stay frozen while busy.
- The interrupt is a single pulse, seen only with a zero count.
- A cancel silences the port.
- A zero-length start goes straight to the interrupt.

Only the bench's scenarios show the following:
- Each address and data value matches the values software programmed, including the relocation base.
- The total beat count is correct.
- The register contents after completion or cancel are correct.

These are swept over lengths, memory latencies and start addresses.

// File: rtl/dma_qw_pkg.sv
package dma_qw_pkg;

  localparam int QW_BYTES = 16;

  localparam int IDX_CTRL = 0;
  localparam int IDX_CNT  = 1;
  localparam int IDX_SRC  = 2;
  localparam int IDX_TGT  = 3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_DONE  = 2'd3
  } dma_st_e;

  // Address of the next beat.
  function automatic logic [63:0] qw_advance(input logic [63:0] addr);
    return addr + 64'(QW_BYTES);
  endfunction

  // Destination address seen by memory.
  function automatic logic [63:0] relocate(input logic [63:0] tgt, input logic [63:0] base);
    return tgt + base;
  endfunction

endpackage

// File: rtl/dma_qw_regs.sv
module dma_qw_regs
  import dma_qw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              beat_done,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [ADDR_W-1:0] src_q,
  output logic [ADDR_W-1:0] tgt_q
);

  localparam int N_PTR = 2;

  logic [ADDR_W-1:0] ptr_q [N_PTR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cfg_we && cfg_idx == IDX_W'(IDX_CNT)) begin
      cnt_q <= cfg_wdata[CNT_W-1:0];
    end else if (beat_done) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  // Source and target pointers share one load/advance structure.
  for (genvar g = 0; g < N_PTR; g++) begin : g_ptr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ptr_q[g] <= '0;
      end else if (cfg_we && cfg_idx == IDX_W'(IDX_SRC + g)) begin
        ptr_q[g] <= cfg_wdata;
      end else if (beat_done) begin
        ptr_q[g] <= ADDR_W'(qw_advance(64'(ptr_q[g])));
      end
    end
  end

  assign src_q = ptr_q[0];
  assign tgt_q = ptr_q[1];

endmodule

// File: rtl/dma_qw_seq.sv
module dma_qw_seq
  import dma_qw_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic              halt,
  input  logic [CNT_W-1:0]  cnt_q,
  input  logic              rd_rdy,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              wr_rdy,
  output logic              rd_req,
  output logic              wr_req,
  output logic [DATA_W-1:0] wr_data,
  output logic              beat_done,
  output logic              busy,
  output logic              active,
  output logic              done_irq
);

  dma_st_e st_q, st_d;
  logic    last_beat;
  logic    capture;

  assign last_beat = (cnt_q == CNT_W'(1));
  assign capture   = (st_q == ST_READ) && rd_rdy && !halt;
  assign beat_done = (st_q == ST_WRITE) && wr_rdy && !halt;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (launch) st_d = (cnt_q == '0) ? ST_DONE : ST_READ;
      ST_READ:  if (halt) st_d = ST_IDLE;
                else if (rd_rdy) st_d = ST_WRITE;
      ST_WRITE: if (halt) st_d = ST_IDLE;
                else if (wr_rdy) st_d = last_beat ? ST_DONE : ST_READ;
      ST_DONE:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wr_data <= '0;
    else if (capture) wr_data <= rd_data;
  end

  assign rd_req   = (st_q == ST_READ);
  assign wr_req   = (st_q == ST_WRITE);
  assign busy     = (st_q != ST_IDLE);
  assign active   = rd_req || wr_req;
  assign done_irq = (st_q == ST_DONE);

endmodule

// File: rtl/dma_qw_copy.sv
module dma_qw_copy
  import dma_qw_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter int                CNT_W     = 16,
  parameter int                DATA_W    = 128,
  parameter int                REG_AW    = 6,
  parameter logic [ADDR_W-1:0] DEST_BASE = 32'h4000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_rdy,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              mem_wr_req,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  input  logic              mem_wr_rdy,
  output logic              ch_done_irq
);

  localparam int IDX_W = REG_AW - 4;

  logic [IDX_W-1:0]  idx_w;
  logic              aligned_w;
  logic              ctrl_wr_w;
  logic              launch_w;
  logic              halt_w;
  logic              cfg_we_w;
  logic              busy_w;
  logic              active_w;
  logic              beat_done_w;
  logic [CNT_W-1:0]  cnt_w;
  logic [ADDR_W-1:0] src_w;
  logic [ADDR_W-1:0] tgt_w;

  assign idx_w     = reg_addr[REG_AW-1:4];
  assign aligned_w = (reg_addr[3:0] == 4'd0);
  assign ctrl_wr_w = reg_wr && aligned_w && (idx_w == IDX_W'(IDX_CTRL));
  assign launch_w  = ctrl_wr_w && reg_wdata[0] && !busy_w;
  assign halt_w    = ctrl_wr_w && !reg_wdata[0] && active_w;
  assign cfg_we_w  = reg_wr && aligned_w && !busy_w;

  dma_qw_regs #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .IDX_W  (IDX_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we_w),
    .cfg_idx   (idx_w),
    .cfg_wdata (reg_wdata),
    .beat_done (beat_done_w),
    .cnt_q     (cnt_w),
    .src_q     (src_w),
    .tgt_q     (tgt_w)
  );

  dma_qw_seq #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (launch_w),
    .halt      (halt_w),
    .cnt_q     (cnt_w),
    .rd_rdy    (mem_rd_rdy),
    .rd_data   (mem_rd_data),
    .wr_rdy    (mem_wr_rdy),
    .rd_req    (mem_rd_req),
    .wr_req    (mem_wr_req),
    .wr_data   (mem_wr_data),
    .beat_done (beat_done_w),
    .busy      (busy_w),
    .active    (active_w),
    .done_irq  (ch_done_irq)
  );

  assign mem_rd_addr = src_w;
  assign mem_wr_addr = ADDR_W'(relocate(64'(tgt_w), 64'(DEST_BASE)));

  always_comb begin
    reg_rdata = '0;
    if (aligned_w) begin
      case (idx_w)
        IDX_W'(IDX_CTRL): reg_rdata = {{(ADDR_W-1){1'b0}}, busy_w};
        IDX_W'(IDX_CNT):  reg_rdata = ADDR_W'(cnt_w);
        IDX_W'(IDX_SRC):  reg_rdata = src_w;
        IDX_W'(IDX_TGT):  reg_rdata = tgt_w;
        default:          reg_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/dma_qw_copy_chk.sv
module dma_qw_copy_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_req,
  input logic              rd_rdy,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              wr_req,
  input logic              wr_rdy,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              irq,
  input logic              launch,
  input logic              halt,
  input logic              busy,
  input logic              beat_done,
  input logic [CNT_W-1:0]  cnt,
  input logic [ADDR_W-1:0] src,
  input logic [ADDR_W-1:0] tgt
);

  AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && wr_req)); // R4

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_rdy && !halt |=> rd_req && $stable(rd_addr)); // R5

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && !wr_rdy && !halt |=> wr_req && $stable(wr_addr) && $stable(wr_data)); // R5

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    beat_done |=> src == $past(src) + ADDR_W'(16) && tgt == $past(tgt) + ADDR_W'(16)); // R4

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    beat_done |=> cnt == $past(cnt) - CNT_W'(1)); // R4

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R6

  AST_IRQ_CNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> cnt == '0); // R6

  AST_ZERO_START: assert property (@(posedge clk) disable iff (!rst_n)
    launch && cnt == '0 |=> irq && !rd_req && !wr_req); // R7

  AST_BUSY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !beat_done |=> $stable(cnt) && $stable(src) && $stable(tgt)); // R8

  AST_HALT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> !rd_req && !wr_req && !irq && !busy); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_req && !wr_req && !irq); // R3

endmodule

bind dma_qw_copy dma_qw_copy_chk #(
  .ADDR_W (ADDR_W),
  .CNT_W  (CNT_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_req    (mem_rd_req),
  .rd_rdy    (mem_rd_rdy),
  .rd_addr   (mem_rd_addr),
  .wr_req    (mem_wr_req),
  .wr_rdy    (mem_wr_rdy),
  .wr_addr   (mem_wr_addr),
  .wr_data   (mem_wr_data),
  .irq       (ch_done_irq),
  .launch    (launch_w),
  .halt      (halt_w),
  .busy      (busy_w),
  .beat_done (beat_done_w),
  .cnt       (cnt_w),
  .src       (src_w),
  .tgt       (tgt_w)
);

// File: tb/test_dma_qw_copy.sv
module test_dma_qw_copy;

  localparam logic [31:0] BASE = 32'h0C00_0000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_wr = 1'b0;
  logic [5:0]   reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic         mem_rd_req;
  logic [31:0]  mem_rd_addr;
  logic         mem_rd_rdy = 1'b0;
  logic [127:0] mem_rd_data = '0;
  logic         mem_wr_req;
  logic [31:0]  mem_wr_addr;
  logic [127:0] mem_wr_data;
  logic         mem_wr_rdy = 1'b0;
  logic         ch_done_irq;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  dma_qw_copy #(.DEST_BASE(BASE)) i_dma_qw_copy (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_rdy(mem_rd_rdy),
    .mem_rd_data(mem_rd_data), .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .mem_wr_rdy(mem_wr_rdy), .ch_done_irq(ch_done_irq)
  );

  function automatic logic [127:0] pat(input logic [31:0] a);
    return {a, ~a, a ^ 32'hA5A5_5A5A, a + 32'd7};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic prog(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = '0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  // mode 0: plain, 1: writes while busy, 2: cancel after two beats
  task automatic run(input int n, input int lat, input int mode,
                     input logic [31:0] s, input logic [31:0] t);
    int beats = 0;
    int irqs = 0;
    int wcnt = 0;
    int after = 0;
    int cyc = 0;
    bit seen_end = 0;
    bit stopped = 0;
    logic [31:0] v;
    prog(6'h10, 32'(n));
    prog(6'h20, s);
    prog(6'h30, t);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 6'h00; reg_wdata = 32'd1;
    while (cyc < 300) begin
      @(negedge clk);
      if (cyc == 0) chk(reg_rdata[0] == 1'b1, "R3 busy after start", reg_rdata, 1);
      if (cyc == 0 && n == 0)
        chk(ch_done_irq && !mem_rd_req, "R7 zero-length irq", ch_done_irq, 1);
      if (ch_done_irq) irqs++;
      if (seen_end && (mem_rd_req || mem_wr_req))
        chk(0, "R6/R9 request after end", {mem_rd_req, mem_wr_req}, 0);
      mem_rd_rdy = 1'b0; mem_wr_rdy = 1'b0; reg_wr = 1'b0; reg_addr = '0;
      if (mode == 1 && cyc == 1) begin reg_wr = 1'b1; reg_addr = 6'h10; reg_wdata = 32'd99; end
      if (mode == 1 && cyc == 2) begin reg_wr = 1'b1; reg_addr = 6'h20; reg_wdata = 32'h0; end
      if (mode == 1 && cyc == 3) begin reg_wr = 1'b1; reg_addr = 6'h00; reg_wdata = 32'd1; end
      if (mode == 2 && beats == 2 && !stopped) begin
        reg_wr = 1'b1; reg_addr = 6'h00; reg_wdata = 32'd0;
        stopped = 1; seen_end = 1;
      end else if (mem_rd_req) begin
        if (wcnt == lat) begin
          chk(mem_rd_addr == s + 32'(16 * beats), "R4 read address", mem_rd_addr, s + 32'(16 * beats));
          mem_rd_data = pat(mem_rd_addr);
          mem_rd_rdy = 1'b1; wcnt = 0;
        end else wcnt++;
      end else if (mem_wr_req) begin
        if (wcnt == lat) begin
          chk(mem_wr_addr == t + BASE + 32'(16 * beats), "R4 write address",
              mem_wr_addr, t + BASE + 32'(16 * beats));
          chk(mem_wr_data == pat(s + 32'(16 * beats)), "R4 write data",
              mem_wr_data, pat(s + 32'(16 * beats)));
          mem_wr_rdy = 1'b1; wcnt = 0; beats++;
        end else wcnt++;
      end
      if (ch_done_irq) seen_end = 1;
      if (seen_end) after++;
      if (after > 3) break;
      cyc++;
    end
    mem_rd_rdy = 1'b0; mem_wr_rdy = 1'b0; reg_wr = 1'b0;
    @(negedge clk);
    if (mode == 2) begin
      chk(beats == 2, "R9 beats before cancel", beats, 2);
      chk(irqs == 0, "R9 no irq on cancel", irqs, 0);
      rd(6'h10, v); chk(v == 32'(n - 2), "R9 remaining count", v, n - 2);
      rd(6'h20, v); chk(v == s + 32'd32, "R9 source progress", v, s + 32'd32);
      rd(6'h30, v); chk(v == t + 32'd32, "R9 target progress", v, t + 32'd32);
      rd(6'h00, v); chk(v == 32'd0, "R9 idle after cancel", v, 0);
    end else begin
      chk(beats == n, "R4 beat total", beats, n);
      chk(irqs == 1, "R6 single irq", irqs, 1);
      rd(6'h10, v); chk(v == 32'd0, "R6 count cleared", v, 0);
      rd(6'h00, v); chk(v == 32'd0, "R6 go bit cleared", v, 0);
      rd(6'h20, v); chk(v == s + 32'(16 * n), "R6 source end", v, s + 32'(16 * n));
      rd(6'h30, v); chk(v == t + 32'(16 * n), "R6 target end", v, t + 32'(16 * n));
      if (mode == 1) chk(beats == n && irqs == 1, "R8 busy writes ignored", beats, n);
    end
    reg_addr = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R1: reset state
    rd(6'h00, v); chk(v == 0, "R1 ctrl reset", v, 0);
    rd(6'h10, v); chk(v == 0, "R1 count reset", v, 0);
    rd(6'h20, v); chk(v == 0, "R1 source reset", v, 0);
    rd(6'h30, v); chk(v == 0, "R1 target reset", v, 0);
    chk(!mem_rd_req && !mem_wr_req && !ch_done_irq, "R1 outputs quiet",
        {mem_rd_req, mem_wr_req, ch_done_irq}, 0);
    @(negedge clk); rst_n = 1'b1;
    // R2: register map
    prog(6'h10, 32'h0001_2345);
    rd(6'h10, v); chk(v == 32'h2345, "R2 count low bits", v, 32'h2345);
    prog(6'h20, 32'hDEAD_BEEF);
    rd(6'h20, v); chk(v == 32'hDEAD_BEEF, "R2 source readback", v, 32'hDEAD_BEEF);
    prog(6'h30, 32'h1357_9BDF);
    rd(6'h30, v); chk(v == 32'h1357_9BDF, "R2 target readback", v, 32'h1357_9BDF);
    prog(6'h14, 32'h55);
    rd(6'h10, v); chk(v == 32'h2345, "R2 unaligned write ignored", v, 32'h2345);
    rd(6'h14, v); chk(v == 0, "R2 unaligned read zero", v, 0);
    prog(6'h00, 32'h0);
    @(negedge clk);
    rd(6'h00, v); chk(v == 0, "R3 clear write idle stays idle", v, 0);
    chk(!mem_rd_req && !mem_wr_req, "R3 no request while idle", {mem_rd_req, mem_wr_req}, 0);
    // Sweep of lengths and latencies
    for (int n = 0; n <= 4; n++)
      for (int lat = 0; lat <= 2; lat++)
        run(n, lat, 0, 32'h1000_0000 + 32'(n * 32'h340) + 32'(lat * 32'h1_0000),
            32'h0000_2000 + 32'(n * 32'h100));
    // R8: writes while busy
    run(2, 0, 1, 32'h0200_0000, 32'h0000_8000);
    run(3, 1, 1, 32'h0300_0040, 32'h0000_9000);
    // R9: cancel
    run(3, 0, 2, 32'h0400_0000, 32'h0000_A000);
    run(5, 1, 2, 32'h0500_0100, 32'h0000_B000);
    // Restart after cancel completes normally
    run(1, 2, 0, 32'h0600_0000, 32'h0000_C000);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule